// File: doc/BRIEF.md
# Floating-point system register bank

This block holds the system registers of a floating-point coprocessor and serves the two instructions a core uses to reach them: a move from a general register into a system register, and a move from a system register into a general register. The core hands over the 32-bit instruction word with a valid strobe, the result of its own condition evaluation, and its current privilege level. For a move-in it also supplies the value of the named general register. For a move-out the block returns the value together with a write enable and the destination index.

Some registers can be reached from any mode. The exception register and the two instruction registers can be reached only from privileged code. Accesses to them from user code are dropped with no error and no side effect. A move-out of the status/control register that names general register 15 does not write a register. It transfers the top four status bits to the core's condition flags.

Top module: `fp_sysreg_bank`

## Requirements
- R1: Instruction fields: condition in bits 31:28, direction in bit 20 (1 = move-out/read, 0 = move-in/write), register selector in bits 19:16, general-register index in bits 15:12. `res_idx` always equals bits 15:12.
- R2: An instruction runs only when `instr_valid` is high and either the condition is 4'hE or `cond_pass` is high. Otherwise it causes no register change, no `res_we` and no `flag_we`.
- R3: A write to selector 1 (status/control) is taken in any mode and commits at the next rising clock edge. A read in the following cycle returns the new value.
- R4: Writes to selector 8 (exception), 9 (instruction 1) and 10 (instruction 2) commit only when `priv` is high. Otherwise they are dropped and the register keeps its value.
- R5: Reads of selector 0 (ID), 1, 6 (feature 1) and 7 (feature 0) raise `res_we` in any mode. Reads of 8, 9 and 10 raise it only when `priv` is high. Reads of any other selector never raise it. `res_data` is zero whenever `res_we` is low.
- R6: A read of selector 1 with index 15 raises `flag_we` instead of `res_we`, with `flags` = {N,Z,C,V} = status bits 31,30,29,28. `res_we` and `flag_we` are never high together.
- R7: After reset the registers read as follows: status 0, exception 0, instruction 1 32'hEE000A00, instruction 2 0, feature 0 32'h11111111, feature 1 0.
- R8: Writes to selectors 0, 6, 7 or any unlisted selector change no register.
- R9: Read data and `flag_we` are combinational from the current instruction, with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Decoded instruction word |
| cond_pass | input | 1 | Condition evaluated true by the core |
| priv | input | 1 | Core is in a privileged mode |
| gpr_data | input | DATA_W | Source general-register value for writes |
| res_we | output | 1 | Destination general-register write enable |
| res_idx | output | 4 | Destination general-register index |
| res_data | output | DATA_W | Value to write to the destination |
| flag_we | output | 1 | Condition-flag write strobe |
| flags | output | 4 | N, Z, C, V values for the flag write |

## Verification
The assertions assume that `priv`, `cond_pass` and `gpr_data` are valid whenever `instr_valid` is high. They also assume these inputs change only away from the active edge, so a write's effect is visible in the cycle after the edge that commits it. The stimulus drives every input on the falling edge and holds it for a full cycle. It idles with `instr_valid` low between groups, and it sweeps all sixteen selector codes in both privilege levels, so the unlisted codes are exercised as well as the named ones.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
   localparam logic [3:0] COND_ALWAYS = 4'hE;
   localparam logic [3:0] IDX_FLAGS   = 4'd15;

   typedef enum logic [3:0] {
      SEL_ID    = 4'd0,
      SEL_STAT  = 4'd1,
      SEL_FEAT1 = 4'd6,
      SEL_FEAT0 = 4'd7,
      SEL_EXC   = 4'd8,
      SEL_INST1 = 4'd9,
      SEL_INST2 = 4'd10
   } fpsr_sel_e;

   // writable slots inside the storage module
   localparam int unsigned SLOT_STAT  = 0;
   localparam int unsigned SLOT_EXC   = 1;
   localparam int unsigned SLOT_INST1 = 2;
   localparam int unsigned SLOT_INST2 = 3;
   localparam int unsigned N_SLOTS    = 4;

   typedef struct packed {
      logic       exec;
      logic       is_rd;
      logic [3:0] sel;
      logic [3:0] idx;
   } fpsr_op_t;
endpackage

// File: rtl/fpsr_decode.sv
module fpsr_decode
   import fpsr_pkg::*;
(
   input  logic        instr_valid,
   input  logic [31:0] instr,
   input  logic        cond_pass,
   output fpsr_op_t    op
);
   logic [3:0] cond_f;

   always_comb begin
      cond_f   = instr[31:28];
      op.exec  = instr_valid && ((cond_f == COND_ALWAYS) || cond_pass);
      op.is_rd = instr[20];
      op.sel   = instr[19:16];
      op.idx   = instr[15:12];
   end
endmodule

// File: rtl/fpsr_access.sv
module fpsr_access
   import fpsr_pkg::*;
(
   input  fpsr_op_t             op,
   input  logic                 priv,
   output logic [N_SLOTS-1:0]   wr_en,
   output logic                 rd_ok,
   output logic                 flag_xfer
);
   logic sel_open;
   logic sel_guarded;

   always_comb begin
      sel_open    = (op.sel == SEL_ID) || (op.sel == SEL_STAT) ||
                    (op.sel == SEL_FEAT1) || (op.sel == SEL_FEAT0);
      sel_guarded = (op.sel == SEL_EXC) || (op.sel == SEL_INST1) ||
                    (op.sel == SEL_INST2);

      wr_en = '0;
      if (op.exec && !op.is_rd) begin
         wr_en[SLOT_STAT]  = (op.sel == SEL_STAT);
         wr_en[SLOT_EXC]   = priv && (op.sel == SEL_EXC);
         wr_en[SLOT_INST1] = priv && (op.sel == SEL_INST1);
         wr_en[SLOT_INST2] = priv && (op.sel == SEL_INST2);
      end

      flag_xfer = op.exec && op.is_rd && (op.sel == SEL_STAT) && (op.idx == IDX_FLAGS);
      rd_ok     = op.exec && op.is_rd && !flag_xfer &&
                  (sel_open || (sel_guarded && priv));
   end
endmodule

// File: rtl/fpsr_store.sv
module fpsr_store
   import fpsr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter logic [N_SLOTS*DATA_W-1:0] RST_VEC = '0
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_SLOTS-1:0]         wr_en,
   input  logic [DATA_W-1:0]          wdata,
   output logic [N_SLOTS*DATA_W-1:0]  q
);
   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[g*DATA_W +: DATA_W] <= RST_VEC[g*DATA_W +: DATA_W];
         else if (wr_en[g])
            q[g*DATA_W +: DATA_W] <= wdata;
      end
   end
endmodule

// File: rtl/fp_sysreg_bank.sv
module fp_sysreg_bank
   import fpsr_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter logic [DATA_W-1:0] ID_VAL    = 32'h0010_0200,
   parameter logic [DATA_W-1:0] FEAT0_VAL = 32'h1111_1111,
   parameter logic [DATA_W-1:0] FEAT1_VAL = 32'h0000_0000,
   parameter logic [DATA_W-1:0] STAT_RST  = 32'h0000_0000,
   parameter logic [DATA_W-1:0] EXC_RST   = 32'h0000_0000,
   parameter logic [DATA_W-1:0] INST1_RST = 32'hEE00_0A00,
   parameter logic [DATA_W-1:0] INST2_RST = 32'h0000_0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr,
   input  logic              cond_pass,
   input  logic              priv,
   input  logic [DATA_W-1:0] gpr_data,
   output logic              res_we,
   output logic [3:0]        res_idx,
   output logic [DATA_W-1:0] res_data,
   output logic              flag_we,
   output logic [3:0]        flags
);
   localparam int unsigned FLAG_LSB = DATA_W - 4;
   localparam logic [N_SLOTS*DATA_W-1:0] RST_VEC = {INST2_RST, INST1_RST, EXC_RST, STAT_RST};

   if (DATA_W < 4) begin : g_bad_width
      $error("fp_sysreg_bank: DATA_W must hold the four flag bits");
   end

   fpsr_op_t                    op;
   logic [N_SLOTS-1:0]          wr_en;
   logic                        rd_ok;
   logic                        flag_xfer;
   logic [N_SLOTS*DATA_W-1:0]   reg_q;
   logic [DATA_W-1:0]           stat_q;
   logic [DATA_W-1:0]           rd_val;

   fpsr_decode u_dec (
      .instr_valid (instr_valid),
      .instr       (instr),
      .cond_pass   (cond_pass),
      .op          (op)
   );

   fpsr_access u_acc (
      .op        (op),
      .priv      (priv),
      .wr_en     (wr_en),
      .rd_ok     (rd_ok),
      .flag_xfer (flag_xfer)
   );

   fpsr_store #(.DATA_W(DATA_W), .RST_VEC(RST_VEC)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wdata (gpr_data),
      .q     (reg_q)
   );

   assign stat_q = reg_q[SLOT_STAT*DATA_W +: DATA_W];

   always_comb begin
      unique case (op.sel)
         SEL_ID:    rd_val = ID_VAL;
         SEL_STAT:  rd_val = stat_q;
         SEL_FEAT1: rd_val = FEAT1_VAL;
         SEL_FEAT0: rd_val = FEAT0_VAL;
         SEL_EXC:   rd_val = reg_q[SLOT_EXC*DATA_W +: DATA_W];
         SEL_INST1: rd_val = reg_q[SLOT_INST1*DATA_W +: DATA_W];
         SEL_INST2: rd_val = reg_q[SLOT_INST2*DATA_W +: DATA_W];
         default:   rd_val = '0;
      endcase
   end

   assign res_we   = rd_ok;
   assign res_idx  = op.idx;
   assign res_data = rd_ok ? rd_val : '0;
   assign flag_we  = flag_xfer;
   assign flags    = stat_q[FLAG_LSB +: 4];
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker #(
   parameter int unsigned DATA_W = 32
)(
   input logic                clk,
   input logic                rst_n,
   input logic                instr_valid,
   input logic [31:0]         instr,
   input logic                cond_pass,
   input logic                priv,
   input logic [DATA_W-1:0]   gpr_data,
   input logic                res_we,
   input logic [DATA_W-1:0]   res_data,
   input logic                flag_we,
   input logic [4*DATA_W-1:0] reg_q
);
   logic       runs;
   logic       rd;
   logic [3:0] sel;

   assign runs = instr_valid && (instr[31:28] == 4'hE || cond_pass);
   assign rd   = instr[20];
   assign sel  = instr[19:16];

   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !runs |-> !res_we && !flag_we);                                   // R2
   AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !runs |=> $stable(reg_q));                                        // R2
   AST_STAT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      runs && !rd && sel == 4'd1 |=> reg_q[DATA_W-1:0] == $past(gpr_data)); // R3
   AST_USER_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      runs && !rd && !priv && sel != 4'd1 |=> $stable(reg_q));          // R4
   AST_USER_READ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      runs && rd && !priv && sel >= 4'd8 |-> !res_we);                  // R5
   AST_ZERO_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !res_we |-> res_data == '0);                                      // R5
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_we && flag_we));                                            // R6
   AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      runs && !rd && (sel == 4'd0 || sel == 4'd6 || sel == 4'd7 || sel > 4'd10) |=> $stable(reg_q)); // R8
endmodule

bind fp_sysreg_bank fpsr_checker #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .cond_pass   (cond_pass),
   .priv        (priv),
   .gpr_data    (gpr_data),
   .res_we      (res_we),
   .res_data    (res_data),
   .flag_we     (flag_we),
   .reg_q       (reg_q)
);

// File: tb/test_fp_sysreg_bank.sv
`timescale 1ns/1ps
module test_fp_sysreg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic        cond_pass = 1'b0;
   logic        priv = 1'b0;
   logic [31:0] gpr_data = '0;
   logic        res_we;
   logic [3:0]  res_idx;
   logic [31:0] res_data;
   logic        flag_we;
   logic [3:0]  flags;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   fp_sysreg_bank i_fp_sysreg_bank (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .cond_pass(cond_pass), .priv(priv), .gpr_data(gpr_data),
      .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
      .flag_we(flag_we), .flags(flags)
   );

   typedef struct {
      logic        we;
      logic [3:0]  idx;
      logic [31:0] data;
      logic        fwe;
      logic [3:0]  fl;
      string       tag;
   } exp_t;

   exp_t exp_q[$];

   // bench model of the register contents
   logic [31:0] m_stat = 32'h0, m_exc = 32'h0, m_i1 = 32'hEE000A00, m_i2 = 32'h0;
   localparam logic [31:0] M_ID = 32'h0010_0200, M_F0 = 32'h1111_1111, M_F1 = 32'h0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic issue(input logic [3:0] cond, input bit rd, input logic [3:0] sel,
                        input logic [3:0] idx, input bit cp, input bit pv,
                        input logic [31:0] gd, input string tag);
      exp_t e;
      bit   runs;
      bit   open;
      bit   guard;
      logic [31:0] v;
      @(negedge clk);
      instr_valid = 1'b1;
      instr       = {cond, 7'd0, rd, sel, idx, 12'h0};
      cond_pass   = cp;
      priv        = pv;
      gpr_data    = gd;
      runs  = (cond == 4'hE) || cp;
      open  = sel inside {4'd0, 4'd1, 4'd6, 4'd7};
      guard = sel inside {4'd8, 4'd9, 4'd10};
      case (sel)
         4'd0: v = M_ID;   4'd1: v = m_stat; 4'd6: v = M_F1; 4'd7: v = M_F0;
         4'd8: v = m_exc;  4'd9: v = m_i1;   4'd10: v = m_i2;
         default: v = 32'h0;
      endcase
      e.fwe  = runs && rd && sel == 4'd1 && idx == 4'd15;
      e.we   = runs && rd && !e.fwe && (open || (guard && pv));
      e.data = e.we ? v : 32'h0;
      e.idx  = idx;
      e.fl   = m_stat[31:28];
      e.tag  = tag;
      exp_q.push_back(e);
      if (runs && !rd) begin
         if (sel == 4'd1) m_stat = gd;
         else if (pv && sel == 4'd8) m_exc = gd;
         else if (pv && sel == 4'd9) m_i1 = gd;
         else if (pv && sel == 4'd10) m_i2 = gd;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      instr_valid = 1'b0;
      cond_pass   = 1'b0;
   endtask

   // monitor: compares one expected item per driven cycle
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(res_we === e.we, e.tag, "res_we", {31'd0, res_we}, {31'd0, e.we});
            chk(res_data === e.data, e.tag, "res_data", res_data, e.data);
            chk(flag_we === e.fwe, e.tag, "flag_we", {31'd0, flag_we}, {31'd0, e.fwe});
            if (e.we)  chk(res_idx === e.idx, "R1", "res_idx", {28'd0, res_idx}, {28'd0, e.idx});
            if (e.fwe) chk(flags === e.fl, "R6", "flags", {28'd0, flags}, {28'd0, e.fl});
         end
      end
   end

   initial begin
      #1_000_000;
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R7 / R9: outputs quiet during reset
      chk(res_we === 1'b0 && flag_we === 1'b0, "R7", "reset outputs",
          {30'd0, res_we, flag_we}, 32'd0);
      rst_n = 1'b1;
      idle();
      // R7: reset values, privileged reads
      for (int s = 0; s < 16; s++) issue(4'hE, 1'b1, 4'(s), 4'd3, 1'b0, 1'b1, 32'h0, "R7");
      idle();
      // R4/R8: unprivileged writes to all selectors, then readback both modes
      for (int s = 0; s < 16; s++)
         if (s != 1) issue(4'hE, 1'b0, 4'(s), 4'd2, 1'b0, 1'b0, 32'hDEAD_0000 + 32'(s), "R8");
      for (int s = 0; s < 16; s++) issue(4'hE, 1'b1, 4'(s), 4'd4, 1'b0, 1'b1, 32'h0, "R4");
      for (int s = 0; s < 16; s++) issue(4'hE, 1'b1, 4'(s), 4'd5, 1'b0, 1'b0, 32'h0, "R5");
      idle();
      // R4: privileged writes to every selector, then reads
      for (int s = 0; s < 16; s++) issue(4'hE, 1'b0, 4'(s), 4'd1, 1'b0, 1'b1, 32'hA5A5_0000 ^ (32'(s) << 8), "R4");
      for (int s = 0; s < 16; s++) issue(4'hE, 1'b1, 4'(s), 4'd6, 1'b0, 1'b1, 32'h0, "R5");
      // R3: write then read next cycle, unprivileged
      issue(4'hE, 1'b0, 4'd1, 4'd7, 1'b0, 1'b0, 32'h1234_5678, "R3");
      issue(4'hE, 1'b1, 4'd1, 4'd7, 1'b0, 1'b0, 32'h0, "R3");
      // R2: conditional, failing and passing
      issue(4'h0, 1'b0, 4'd1, 4'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, "R2");
      issue(4'h0, 1'b1, 4'd1, 4'd8, 1'b0, 1'b1, 32'h0, "R2");
      issue(4'hE, 1'b1, 4'd1, 4'd8, 1'b0, 1'b1, 32'h0, "R2");
      issue(4'h3, 1'b0, 4'd1, 4'd0, 1'b1, 1'b0, 32'hCAFE_F00D, "R2");
      issue(4'h3, 1'b1, 4'd1, 4'd9, 1'b1, 1'b0, 32'h0, "R2");
      issue(4'h1, 1'b1, 4'd1, 4'd15, 1'b0, 1'b1, 32'h0, "R2");
      // R6: flag transfer for every top-nibble pattern
      for (int p = 0; p < 16; p++) begin
         issue(4'hE, 1'b0, 4'd1, 4'd0, 1'b0, 1'b0, {4'(p), 28'h0ABCDEF}, "R6");
         issue(4'hE, 1'b1, 4'd1, 4'd15, 1'b0, p[0], 32'h0, "R6");
      end
      // R9: idle cycle produces nothing
      idle();
      @(negedge clk); #1;
      chk(res_we === 1'b0 && flag_we === 1'b0, "R9", "idle outputs",
          {30'd0, res_we, flag_we}, 32'd0);
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule